// File: doc/BRIEF.md
# Serial FIFO Front End with Watermark Interrupts

This block sits between a register bus and the byte-level halves of a serial port. Software writes bursts of bytes into an eight-entry transmit queue, and a serializer takes them one at a time over a valid/ready port. A deserializer pushes received bytes into a second eight-entry queue, and software drains that queue by reading a data register. Line timing and baud generation sit outside the block.

Each direction has a programmable watermark. Transmit pending means the transmit queue holds fewer bytes than its watermark, so it is running low. Receive pending means the receive queue holds more bytes than its watermark, so it is filling up. The single level-sensitive interrupt line is the OR of each pending bit gated by its enable bit. The transmit contribution reaches the pin a fixed number of clock cycles late. A transmit burst that does not fit is cut to the free space, and a sticky overflow bit records the loss.

Top module: `serial_wm_intc`

## Requirements
- R1: After reset both queues are empty, both watermarks, both enables and the overflow bit are zero, and `irq` is low.
- R2: A write to address 0 pushes `bus_wlen` bytes taken from `bus_wdata`, lowest byte lane first. `tx_out_valid` is high whenever the transmit queue is not empty, and `tx_out_data` shows the oldest byte. A byte is removed on each cycle where valid and ready are both high.
- R3: A burst is clamped to 4 bytes. Free space is measured before any pop in the same cycle. If the burst is larger than the free space, only the free space is accepted, the rest is dropped, and the overflow bit (bit 0 of address 6) is set.
- R4: The overflow bit stays set until software writes address 6 with bit 0 equal to one. A write with bit 0 equal to zero leaves it set.
- R5: A transmit write with a length of zero leaves the transmit queue and the overflow bit unchanged.
- R6: Reading address 0 returns bit 31 set when the transmit queue holds 8 bytes, and zero in every other bit.
- R7: Address 2 bits [2:0] hold the transmit watermark. The transmit pending bit (address 5 bit 0, read-only) is one exactly when the transmit count is strictly less than that watermark.
- R8: Address 3 bits [2:0] hold the receive watermark. The receive pending bit (address 5 bit 1, read-only) is one exactly when the receive count is strictly greater than that watermark.
- R9: Address 4 bit 0 enables the transmit interrupt and bit 1 enables the receive interrupt. `irq` is the OR of the delayed transmit term and (receive pending AND its enable). An enable with no pending bit does not raise `irq`.
- R10: The transmit term (transmit pending AND its enable) reaches `irq` exactly `TX_DLY` clock cycles after it changes (default 25 cycles, which is 100 ns at 250 MHz). The receive term acts in the cycle it changes.
- R11: `rx_in_ready` is high while the receive queue holds fewer than 8 bytes. Reading address 1 returns the oldest byte in bits [7:0], or bit 31 alone when the queue is empty. Asserting `bus_re` during that read removes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Read strobe; pops the receive queue when the address is 1 |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data; byte lanes for transmit bursts |
| bus_wlen | input | 3 | Byte count of a transmit burst write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_data | output | 8 | Oldest transmit byte |
| tx_out_ready | input | 1 | Serializer takes the byte |
| rx_in_valid | input | 1 | Deserializer offers a byte |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive queue has space |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the strict edges of both comparisons. With the transmit count equal to its watermark, or the receive count equal to its watermark, the bit must read zero; a design using a non-strict compare raises the interrupt one byte early. It fills the transmit queue to one free slot and then writes a four-byte burst, including a burst that arrives in the same cycle as a pop. A design that measures free space after the pop, or that wraps the count, loses or duplicates bytes in the serializer stream. It also checks that the interrupt does not fire when only an enable is set, and that the transmit interrupt appears and disappears exactly `TX_DLY` cycles late. A design that ORs in the enables, or that delays the receive path as well, misses those cycles.

// File: rtl/serial_wm_pkg.sv
package serial_wm_pkg;
    typedef enum logic [2:0] {
        REG_TXDATA = 3'd0,
        REG_RXDATA = 3'd1,
        REG_TXCTRL = 3'd2,
        REG_RXCTRL = 3'd3,
        REG_IE     = 3'd4,
        REG_IP     = 3'd5,
        REG_STAT   = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/wm_fifo.sv
// Byte queue accepting up to MAXW bytes per cycle and releasing one.
module wm_fifo #(
    parameter int DEPTH = 8,
    parameter int MAXW  = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(MAXW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LW-1:0]     push_len,
    input  logic [MAXW*8-1:0] push_data,
    input  logic              pop,
    output logic [7:0]        head,
    output logic [CW-1:0]     count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } q_t;

    q_t q_d, q_q;
    logic [CW:0] free_w, len_w, take_w;
    logic        do_pop;

    always_comb begin
        free_w = (CW+1)'(DEPTH) - (CW+1)'(q_q.cnt);
        len_w  = (CW+1)'(push_len);
        take_w = (len_w > free_w) ? free_w : len_w;
        do_pop = pop && (q_q.cnt != '0);
        q_d    = q_q;
        for (int i = 0; i < MAXW; i++) begin
            if ((CW+1)'(i) < take_w) begin
                q_d.mem[q_q.wp + PW'(i)] = push_data[i*8 +: 8];
            end
        end
        q_d.wp  = q_q.wp + PW'(take_w);
        q_d.rp  = q_q.rp + PW'(do_pop);
        q_d.cnt = q_q.cnt + CW'(take_w) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rp];
    assign count = q_q.cnt;
endmodule

// File: rtl/wm_irq.sv
// Watermark comparisons, enable gating and transmit-path delay.
module wm_irq #(
    parameter int CW     = 4,
    parameter int WM_W   = 3,
    parameter int TX_DLY = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   tx_cnt,
    input  logic [CW-1:0]   rx_cnt,
    input  logic [WM_W-1:0] tx_wm,
    input  logic [WM_W-1:0] rx_wm,
    input  logic [1:0]      ie,
    output logic [1:0]      pend,
    output logic            irq
);
    logic tx_term, rx_term, tx_late;

    always_comb begin
        pend[0] = 32'(tx_cnt) < 32'(tx_wm);
        pend[1] = 32'(rx_cnt) > 32'(rx_wm);
        tx_term = pend[0] & ie[0];
        rx_term = pend[1] & ie[1];
    end

    if (TX_DLY == 0) begin : g_nodly
        assign tx_late = tx_term;
    end else begin : g_dly
        logic [TX_DLY-1:0] pipe_d, pipe_q;
        always_comb pipe_d = (pipe_q << 1) | TX_DLY'(tx_term);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end
        assign tx_late = pipe_q[TX_DLY-1];
    end

    assign irq = tx_late | rx_term;
endmodule

// File: rtl/serial_wm_intc.sv
module serial_wm_intc
    import serial_wm_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MAXW   = 4,
    parameter int WM_W   = 3,
    parameter int TX_DLY = 25,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int LW = $clog2(MAXW + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [LW-1:0] bus_wlen,
    output logic [31:0] bus_rdata,
    output logic        tx_out_valid,
    output logic [7:0]  tx_out_data,
    input  logic        tx_out_ready,
    input  logic        rx_in_valid,
    input  logic [7:0]  rx_in_data,
    output logic        rx_in_ready,
    output logic        irq
);
    typedef struct packed {
        logic [WM_W-1:0] tx_wm;
        logic [WM_W-1:0] rx_wm;
        logic [1:0]      ie;
        logic            ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [7:0]    tx_head, rx_head;
    logic [1:0]    pend;
    logic [LW-1:0] len_eff, tx_len;
    logic [CW:0]   tx_free;
    logic          tx_wr, tx_pop, rx_pop, rx_push, rx_empty;

    always_comb begin
        tx_wr    = bus_we && (bus_addr == REG_TXDATA);
        len_eff  = (32'(bus_wlen) > MAXW) ? LW'(MAXW) : bus_wlen;
        tx_len   = tx_wr ? len_eff : '0;
        tx_free  = (CW+1)'(DEPTH) - (CW+1)'(tx_cnt);
        tx_pop   = tx_out_ready && tx_out_valid;
        rx_pop   = bus_re && (bus_addr == REG_RXDATA);
        rx_push  = rx_in_valid && rx_in_ready;
        rx_empty = (rx_cnt == '0);

        ctl_d = ctl_q;
        if (tx_wr && ((CW+1)'(len_eff) > tx_free)) ctl_d.ovf = 1'b1;
        if (bus_we) begin
            case (bus_addr)
                REG_TXCTRL: ctl_d.tx_wm = bus_wdata[WM_W-1:0];
                REG_RXCTRL: ctl_d.rx_wm = bus_wdata[WM_W-1:0];
                REG_IE:     ctl_d.ie    = bus_wdata[1:0];
                REG_STAT:   if (bus_wdata[0]) ctl_d.ovf = 1'b0;
                default:    ;
            endcase
        end

        case (bus_addr)
            REG_TXDATA: bus_rdata = {tx_cnt == CW'(DEPTH), 31'b0};
            REG_RXDATA: bus_rdata = {rx_empty, 23'b0, rx_empty ? 8'h00 : rx_head};
            REG_TXCTRL: bus_rdata = 32'(ctl_q.tx_wm);
            REG_RXCTRL: bus_rdata = 32'(ctl_q.rx_wm);
            REG_IE:     bus_rdata = 32'(ctl_q.ie);
            REG_IP:     bus_rdata = 32'(pend);
            REG_STAT:   bus_rdata = 32'(ctl_q.ovf);
            default:    bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    wm_fifo #(.DEPTH(DEPTH), .MAXW(MAXW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_len  (tx_len),
        .push_data (bus_wdata[MAXW*8-1:0]),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_cnt)
    );

    wm_fifo #(.DEPTH(DEPTH), .MAXW(1)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_len  (rx_push),
        .push_data (rx_in_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    wm_irq #(.CW(CW), .WM_W(WM_W), .TX_DLY(TX_DLY)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_cnt (tx_cnt),
        .rx_cnt (rx_cnt),
        .tx_wm  (ctl_q.tx_wm),
        .rx_wm  (ctl_q.rx_wm),
        .ie     (ctl_q.ie),
        .pend   (pend),
        .irq    (irq)
    );

    assign tx_out_valid = (tx_cnt != '0);
    assign tx_out_data  = tx_head;
    assign rx_in_ready  = (rx_cnt != CW'(DEPTH));
endmodule

// File: rtl/serial_wm_intc_chk.sv
module serial_wm_intc_chk #(
    parameter int DEPTH = 8,
    parameter int MAXW  = 4,
    parameter int WM_W  = 3,
    parameter int CW    = 4,
    parameter int LW    = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_we,
    input logic [2:0]      bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [LW-1:0]   bus_wlen,
    input logic [31:0]     bus_rdata,
    input logic            tx_out_valid,
    input logic            tx_out_ready,
    input logic            irq,
    input logic [CW-1:0]   tx_cnt,
    input logic [CW-1:0]   rx_cnt,
    input logic [WM_W-1:0] rx_wm,
    input logic [1:0]      ie,
    input logic            ovf
);
    assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tx_cnt) <= DEPTH);

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd0 && 32'(bus_wlen) <= MAXW &&
         32'(bus_wlen) > DEPTH - 32'(tx_cnt)) |=> ovf);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(bus_we && bus_addr == 3'd6 && bus_wdata[0])) |=> ovf);

    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd0 && bus_wlen == '0 &&
         !(tx_out_valid && tx_out_ready)) |=> $stable(tx_cnt));

    assert_full_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_cnt) == DEPTH && bus_addr == 3'd0) |-> bus_rdata[31]);

    assert_rx_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_cnt) > 32'(rx_wm) && ie[1]) |-> irq);
endmodule

bind serial_wm_intc serial_wm_intc_chk #(
    .DEPTH(DEPTH), .MAXW(MAXW), .WM_W(WM_W), .CW(CW), .LW(LW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wlen     (bus_wlen),
    .bus_rdata    (bus_rdata),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .irq          (irq),
    .tx_cnt       (tx_cnt),
    .rx_cnt       (rx_cnt),
    .rx_wm        (ctl_q.rx_wm),
    .ie           (ctl_q.ie),
    .ovf          (ctl_q.ovf)
);

// File: tb/serial_wm_intc_tb.sv
module serial_wm_intc_tb;
    localparam int DEPTH = 8;
    localparam int DLY   = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, re = 1'b0, txr = 1'b0, rxv = 1'b0;
    logic [2:0]  addr = 3'd0, wlen = 3'd0;
    logic [31:0] wdata = '0;
    logic [7:0]  rxd = '0;
    logic [31:0] rdata;
    logic        txv, rxr, irq;
    logic [7:0]  txd;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit         dq[$];
    int         txwm = 0, rxwm = 0, ie = 0, ovf = 0;

    always #2 clk = ~clk;

    serial_wm_intc #(.DEPTH(DEPTH), .MAXW(4), .WM_W(3), .TX_DLY(DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
        .bus_wdata(wdata), .bus_wlen(wlen), .bus_rdata(rdata),
        .tx_out_valid(txv), .tx_out_data(txd), .tx_out_ready(txr),
        .rx_in_valid(rxv), .rx_in_data(rxd), .rx_in_ready(rxr), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete(); dq.delete();
            for (int i = 0; i < DLY; i++) dq.push_back(1'b0);
            txwm = 0; rxwm = 0; ie = 0; ovf = 0;
        end else begin
            int free_n, len_n, take_n;
            bit rdy;
            dq.push_back((txq.size() < txwm) && ie[0]);
            void'(dq.pop_front());
            free_n = DEPTH - txq.size();
            if (txr && txq.size() > 0) void'(txq.pop_front());
            rdy = rxq.size() < DEPTH;
            if (re && addr == 3'd1 && rxq.size() > 0) void'(rxq.pop_front());
            if (rxv && rdy) rxq.push_back(rxd);
            if (we) begin
                case (addr)
                    3'd0: begin
                        len_n  = (wlen > 4) ? 4 : int'(wlen);
                        take_n = (len_n > free_n) ? free_n : len_n;
                        for (int i = 0; i < take_n; i++) txq.push_back(wdata[i*8 +: 8]);
                        if (len_n > free_n) ovf = 1;
                    end
                    3'd2: txwm = int'(wdata[2:0]);
                    3'd3: rxwm = int'(wdata[2:0]);
                    3'd4: ie   = int'(wdata[1:0]);
                    3'd6: if (wdata[0]) ovf = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        logic txp, rxp;
        txp = txq.size() < txwm;
        rxp = rxq.size() > rxwm;
        case (addr)
            3'd0: return {txq.size() == DEPTH, 31'b0};
            3'd1: return (rxq.size() == 0) ? 32'h8000_0000 : {24'b0, rxq[0]};
            3'd2: return 32'(txwm);
            3'd3: return 32'(rxwm);
            3'd4: return 32'(ie);
            3'd5: return {30'b0, rxp, txp};
            3'd6: return 32'(ovf);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rtag();
        case (addr)
            3'd0: return "R6 txdata";
            3'd1: return "R11 rxdata";
            3'd5: return "R7 R8 pending";
            3'd6: return "R3 R4 overflow";
            default: return "R1 control";
        endcase
    endfunction

    task automatic compare_all();
        logic exp_irq;
        exp_irq = dq[0] | ((rxq.size() > rxwm) && ie[1]);
        chk("R9 R10 irq", {31'b0, irq}, {31'b0, exp_irq});
        chk("R2 tx_out_valid", {31'b0, txv}, {31'b0, txq.size() > 0});
        if (txq.size() > 0) chk("R2 tx_out_data", {24'b0, txd}, {24'b0, txq[0]});
        chk("R11 rx_in_ready", {31'b0, rxr}, {31'b0, rxq.size() < DEPTH});
        chk(rtag(), rdata, exp_rdata());
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, logic [2:0] n);
        we = 1'b1; addr = a; wdata = d; wlen = n;
        tick();
        we = 1'b0; wlen = 3'd0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic look(logic [2:0] a);
        addr = a;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1: reset values seen through every register
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 7; a++) look(3'(a));

        // R9: enable alone with nothing pending keeps irq low
        wr(3'd4, 32'h3, 3'd0);
        idle(DLY + 3);
        chk("R9 enable without pending", {31'b0, irq}, 32'h0);

        // R7 R10: tx watermark 4 on an empty queue, irq appears after the delay
        wr(3'd2, 32'h4, 3'd0);
        chk("R10 no early irq", {31'b0, irq}, 32'h0);
        idle(DLY + 2);
        chk("R10 irq after delay", {31'b0, irq}, 32'h1);
        look(3'd5);

        // R2 R7: three bytes (below mark), then four more (7, at/above mark)
        wr(3'd0, 32'h00_33_22_11, 3'd3);
        look(3'd5);
        wr(3'd0, 32'h77_66_55_44, 3'd4);
        look(3'd5);
        idle(DLY + 2);
        look(3'd0);

        // R3 R6: one free slot, four-byte burst keeps one and flags overflow
        wr(3'd0, 32'hBB_AA_99_88, 3'd4);
        look(3'd0);
        chk("R6 full flag", rdata, 32'h8000_0000);
        look(3'd6);
        chk("R3 overflow set", rdata, 32'h1);

        // R5: zero-length write while full changes nothing
        wr(3'd0, 32'hDEAD_BEEF, 3'd0);
        look(3'd0);
        // R4: write of zero keeps, write of one clears
        wr(3'd6, 32'h0, 3'd0);
        look(3'd6);
        chk("R4 sticky", rdata, 32'h1);
        wr(3'd6, 32'h1, 3'd0);
        look(3'd6);
        chk("R4 cleared", rdata, 32'h0);
        // R5: zero-length write with room leaves overflow clear
        txr = 1'b1; tick(); txr = 1'b0;
        wr(3'd0, 32'h12345678, 3'd0);
        look(3'd6);
        chk("R5 zero length no overflow", rdata, 32'h0);

        // R3: full queue, write in the same cycle as a pop -> still overflow
        wr(3'd0, 32'h000000C1, 3'd1);
        txr = 1'b1;
        wr(3'd0, 32'h0000D2D1, 3'd2);
        txr = 1'b0;
        look(3'd6);
        wr(3'd6, 32'h1, 3'd0);

        // R2 R10: drain in order, pending returns, then disable tx
        txr = 1'b1;
        idle(10);
        txr = 1'b0;
        look(3'd5);
        idle(DLY + 2);
        wr(3'd4, 32'h2, 3'd0);
        idle(DLY + 2);

        // R3: length above four is clamped
        wr(3'd0, 32'hF4_F3_F2_F1, 3'd7);
        txr = 1'b1; idle(6); txr = 1'b0;

        // R8 R11: rx watermark 2, count 2 not pending, 3 pending
        wr(3'd3, 32'h2, 3'd0);
        rxv = 1'b1;
        for (int i = 0; i < 3; i++) begin
            rxd = 8'h30 + 8'(i);
            look(3'd5);
        end
        rxv = 1'b0;
        chk("R8 rx pending irq", {31'b0, irq}, 32'h1);
        // fill to full, ready drops
        rxv = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rxd = 8'h40 + 8'(i);
            look(3'd1);
        end
        rxv = 1'b0;
        chk("R11 full not ready", {31'b0, rxr}, 32'h0);
        // drain by reads, past empty
        re = 1'b1;
        for (int i = 0; i < 10; i++) look(3'd1);
        re = 1'b0;
        look(3'd5);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            we    = ($urandom % 3) == 0;
            addr  = 3'($urandom % 7);
            wdata = $urandom;
            wlen  = 3'($urandom % 8);
            re    = $urandom % 2;
            txr   = ($urandom % 3) == 0;
            rxv   = $urandom % 2;
            rxd   = 8'($urandom);
            tick();
        end
        we = 1'b0; re = 1'b0; txr = 1'b0; rxv = 1'b0;
        idle(DLY + 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule